// File: doc/BRIEF.md
# Dual-Core Interrupt Router with Vectoring

This block sits between the interrupt and exception sources of a two-core machine and the cores themselves. Each core gets a one-cycle entry strobe with the handler address of the event it accepted. The block also keeps that core's interrupt-disable bit, which is set on entry and cleared when the core reports it has left privileged mode.

The disk and terminal lines only reach the primary core (core 0). Timer interrupts, software interrupts and exceptions are handled separately for each core. Software interrupt number 19 is vectored into the extended memory region at 66560, the first address of page 130. All other handler addresses are parameters and are the same for both cores. Each core has an enable input. The system drives it low to hold the secondary core off while the machine is in reset mode.

All pins are plain control pins. Entry strobes are not handshaked and cannot be stalled: a core must act on a strobe in the cycle it appears. Exception and software-interrupt requests are single-cycle samples. A request that loses arbitration is not stored, and the core raises it again. Hardware interrupt pulses are latched until they are accepted.

Top module: `intr_router`

## Requirements
- R1: While reset is asserted, both entry strobes and both interrupt-disable bits read 0.
- R2: Disk and terminal pulses are latched and delivered only to core 0, never to core 1. Among latched hardware interrupts, timer wins over disk, and disk wins over terminal.
- R3: Timer, software-interrupt and exception inputs of one core affect only that core's strobe, address and disable bit.
- R4: An exception or software request in cycle k gives a strobe in cycle k+1. A hardware pulse in cycle k is latched at the edge ending cycle k, so its strobe is no earlier than cycle k+2. Each strobe lasts one cycle.
- R5: When several events are ready in one cycle, an exception wins over a software interrupt, and a software interrupt wins over any hardware interrupt. The losing exception or software request is dropped. Exceptions and software interrupts are accepted even while the disable bit is set.
- R6: Each strobe sets that core's disable bit from the next cycle on. The disable bit is cleared by the core's privileged-exit input. If a strobe and an exit happen in the same cycle, the bit is set.
- R7: A latched hardware interrupt is not accepted while the disable bit is set. It stays latched and is taken once the bit is clear.
- R8: While a core's enable is low, it gets no strobes, its latched interrupts are discarded, its incoming interrupts are ignored and its disable bit reads 0.
- R9: Software interrupt number n (5-bit field) vectors to 66560 when n is 19. Otherwise it vectors to SWI_BASE + n*SWI_STRIDE.
- R10: The default vectors are: exception 2048, timer 4096, disk 5120, terminal 6144, SWI_BASE 8192 and SWI_STRIDE 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_en | input | 2 | Per-core enable; bit 1 low holds the secondary core off |
| disk_irq | input | 1 | Disk interrupt pulse (core 0 only) |
| term_irq | input | 1 | Terminal interrupt pulse (core 0 only) |
| timer_irq | input | 2 | Per-core timer interrupt pulse |
| exc_req | input | 2 | Per-core exception request |
| swi_req | input | 2 | Per-core software interrupt request |
| swi_num | input | 2x5 | Per-core software interrupt number |
| priv_exit | input | 2 | Per-core return from privileged mode |
| entry_vld | output | 2 | Per-core handler entry strobe |
| entry_addr | output | 2x17 | Per-core handler address, valid with the strobe |
| intr_dis | output | 2 | Per-core interrupt-disable bit |

## Verification
A wrong latched-interrupt bit shows up at the ports as a strobe that is missing or extra. This happens on the first cycle where that core's disable bit is clear and no exception or software request is present. A wrong disable bit shows on `intr_dis` in the very next cycle, and it also moves the cycle in which pending hardware interrupts are taken. Wrong routing or a wrong vector shows as a wrong `entry_addr` in the cycle right after the event. Random traffic therefore exposes an internal fault within a few cycles of the first event that touches it.

// File: rtl/intr_router_pkg.sv
package intr_router_pkg;
  // bit positions inside a core's latched hardware-interrupt vector
  localparam int HW_TIMER = 2;
  localparam int HW_DISK  = 1;
  localparam int HW_TERM  = 0;
  localparam int HW_N     = 3;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_EXC, SRC_SWI, SRC_TIMER, SRC_DISK, SRC_TERM
  } src_e;
endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch
  import intr_router_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [HW_N-1:0] raise,
  input  logic [HW_N-1:0] take,
  output logic [HW_N-1:0] pend
);
  always_ff @(posedge clk) begin
    if (!rst_n)   pend <= '0;
    else if (!en) pend <= '0;
    else          pend <= (pend & ~take) | raise;
  end

  // R7
  hold_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pend[HW_TIMER] && !take[HW_TIMER]) |=> pend[HW_TIMER]);

  // R7
  take_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((take & ~pend) == '0));
endmodule

// File: rtl/core_arb.sv
module core_arb
  import intr_router_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int NUM_W      = 5,
  parameter int EXC_VEC    = 2048,
  parameter int TIMER_VEC  = 4096,
  parameter int DISK_VEC   = 5120,
  parameter int TERM_VEC   = 6144,
  parameter int SWI_BASE   = 8192,
  parameter int SWI_STRIDE = 1024,
  parameter int EXT_NUM    = 19,
  parameter int EXT_VEC    = 66560
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              exc,
  input  logic              swi,
  input  logic [NUM_W-1:0]  num,
  input  logic [HW_N-1:0]   pend,
  input  logic              exit_priv,
  output logic [HW_N-1:0]   take,
  output logic              vld_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              dis_q
);
  src_e              sel;
  logic [ADDR_W-1:0] vec;

  always_comb begin
    sel  = SRC_NONE;
    take = '0;
    if (en) begin
      if (exc)      sel = SRC_EXC;
      else if (swi) sel = SRC_SWI;
      else if (!dis_q) begin
        if (pend[HW_TIMER]) begin
          sel = SRC_TIMER; take[HW_TIMER] = 1'b1;
        end else if (pend[HW_DISK]) begin
          sel = SRC_DISK;  take[HW_DISK]  = 1'b1;
        end else if (pend[HW_TERM]) begin
          sel = SRC_TERM;  take[HW_TERM]  = 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (sel)
      SRC_EXC:   vec = ADDR_W'(EXC_VEC);
      SRC_SWI:   vec = (int'(num) == EXT_NUM) ? ADDR_W'(EXT_VEC)
                     : ADDR_W'(SWI_BASE) + ADDR_W'(num) * ADDR_W'(SWI_STRIDE);
      SRC_TIMER: vec = ADDR_W'(TIMER_VEC);
      SRC_DISK:  vec = ADDR_W'(DISK_VEC);
      SRC_TERM:  vec = ADDR_W'(TERM_VEC);
      default:   vec = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      dis_q  <= 1'b0;
    end else begin
      vld_q  <= (sel != SRC_NONE);
      addr_q <= vec;
      if (!en)                  dis_q <= 1'b0;
      else if (sel != SRC_NONE) dis_q <= 1'b1;
      else if (exit_priv)       dis_q <= 1'b0;
    end
  end

  // R6
  dis_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dis_q) |-> vld_q);

  // R5
  exc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && exc) |=> (vld_q && addr_q == ADDR_W'(EXC_VEC)));

  // R8
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!vld_q && !dis_q));

  // R7
  hw_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && (addr_q == ADDR_W'(TIMER_VEC) || addr_q == ADDR_W'(DISK_VEC)
               || addr_q == ADDR_W'(TERM_VEC))) |-> !$past(dis_q));
endmodule

// File: rtl/intr_router.sv
module intr_router
  import intr_router_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int NUM_W      = 5,
  parameter int EXC_VEC    = 2048,
  parameter int TIMER_VEC  = 4096,
  parameter int DISK_VEC   = 5120,
  parameter int TERM_VEC   = 6144,
  parameter int SWI_BASE   = 8192,
  parameter int SWI_STRIDE = 1024,
  parameter int EXT_NUM    = 19,
  parameter int EXT_VEC    = 66560
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   core_en,
  input  logic                         disk_irq,
  input  logic                         term_irq,
  input  logic [1:0]                   timer_irq,
  input  logic [1:0]                   exc_req,
  input  logic [1:0]                   swi_req,
  input  logic [1:0][NUM_W-1:0]        swi_num,
  input  logic [1:0]                   priv_exit,
  output logic [1:0]                   entry_vld,
  output logic [1:0][ADDR_W-1:0]       entry_addr,
  output logic [1:0]                   intr_dis
);
  localparam int NCORE = 2;

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic [HW_N-1:0] raise, pend, take;

    if (c == 0) begin : g_dev
      assign raise = {timer_irq[c], disk_irq, term_irq};
    end else begin : g_nodev
      assign raise = {timer_irq[c], 2'b00};
    end

    irq_pend_latch u_pend (
      .clk(clk), .rst_n(rst_n), .en(core_en[c]),
      .raise(raise), .take(take), .pend(pend)
    );

    core_arb #(
      .ADDR_W(ADDR_W), .NUM_W(NUM_W), .EXC_VEC(EXC_VEC),
      .TIMER_VEC(TIMER_VEC), .DISK_VEC(DISK_VEC), .TERM_VEC(TERM_VEC),
      .SWI_BASE(SWI_BASE), .SWI_STRIDE(SWI_STRIDE),
      .EXT_NUM(EXT_NUM), .EXT_VEC(EXT_VEC)
    ) u_arb (
      .clk(clk), .rst_n(rst_n), .en(core_en[c]),
      .exc(exc_req[c]), .swi(swi_req[c]), .num(swi_num[c]),
      .pend(pend), .exit_priv(priv_exit[c]), .take(take),
      .vld_q(entry_vld[c]), .addr_q(entry_addr[c]), .dis_q(intr_dis[c])
    );
  end

  // R2
  no_dev_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_vld[1] |-> (entry_addr[1] != ADDR_W'(DISK_VEC)
                      && entry_addr[1] != ADDR_W'(TERM_VEC)));

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (entry_vld == 2'b00 && intr_dis == 2'b00));
endmodule

// File: tb/intr_router_test.sv
module intr_router_test;
  localparam int AW = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0] core_en = '0, timer_irq = '0, exc_req = '0, swi_req = '0, priv_exit = '0;
  logic disk_irq = 1'b0, term_irq = 1'b0;
  logic [1:0][4:0] swi_num = '0;
  logic [1:0] entry_vld, intr_dis;
  logic [1:0][AW-1:0] entry_addr;

  intr_router uut (
    .clk(clk), .rst_n(rst_n), .core_en(core_en), .disk_irq(disk_irq),
    .term_irq(term_irq), .timer_irq(timer_irq), .exc_req(exc_req),
    .swi_req(swi_req), .swi_num(swi_num), .priv_exit(priv_exit),
    .entry_vld(entry_vld), .entry_addr(entry_addr), .intr_dis(intr_dis)
  );

  bit       m_dis [2];
  bit [2:0] m_pend[2];
  bit       e_vld [2];
  int       e_addr[2];
  string    e_tag [2];
  int total = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int swi_vec(int n);
    return (n == 19) ? 66560 : 8192 + n * 1024;  // R9
  endfunction

  task automatic model_step();
    for (int c = 0; c < 2; c++) begin
      bit [2:0] raise, take;
      raise = {timer_irq[c], (c == 0) ? disk_irq : 1'b0, (c == 0) ? term_irq : 1'b0};
      take = '0;
      e_vld[c] = 0; e_addr[c] = 0; e_tag[c] = "R4";
      if (!core_en[c]) begin
        m_dis[c] = 0; m_pend[c] = '0; e_tag[c] = "R8";
      end else begin
        if (exc_req[c]) begin
          e_vld[c] = 1; e_addr[c] = 2048; e_tag[c] = "R5";
        end else if (swi_req[c]) begin
          e_vld[c] = 1; e_addr[c] = swi_vec(int'(swi_num[c]));
          e_tag[c] = (swi_num[c] == 5'd19) ? "R9" : "R3";
        end else if (!m_dis[c] && m_pend[c] != 0) begin
          e_vld[c] = 1;
          if (m_pend[c][2])      begin take = 3'b100; e_addr[c] = 4096; e_tag[c] = "R10"; end
          else if (m_pend[c][1]) begin take = 3'b010; e_addr[c] = 5120; e_tag[c] = "R2";  end
          else                   begin take = 3'b001; e_addr[c] = 6144; e_tag[c] = "R2";  end
        end else if (m_dis[c] && m_pend[c] != 0) e_tag[c] = "R7";
        if (e_vld[c]) m_dis[c] = 1;
        else if (priv_exit[c]) m_dis[c] = 0;
        m_pend[c] = (m_pend[c] & ~take) | raise;
      end
    end
  endtask

  task automatic cyc(logic [1:0] en, logic [1:0] tm, logic dk, logic tr,
                     logic [1:0] ex, logic [1:0] sw, logic [4:0] n0,
                     logic [4:0] n1, logic [1:0] pe);
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      chk(e_tag[c], int'(entry_vld[c]), int'(e_vld[c]));
      if (e_vld[c]) chk(e_tag[c], int'(entry_addr[c]), e_addr[c]);
      chk("R6", int'(intr_dis[c]), int'(m_dis[c]));
    end
    core_en = en; timer_irq = tm; disk_irq = dk; term_irq = tr;
    exc_req = ex; swi_req = sw; swi_num[0] = n0; swi_num[1] = n1; priv_exit = pe;
    model_step();
  endtask

  function automatic logic pr(int n);
    return ($urandom_range(n - 1) == 0);
  endfunction

  function automatic logic [4:0] rnum();
    return pr(4) ? 5'd19 : 5'($urandom_range(31));
  endfunction

  initial begin
    logic [1:0] en;
    void'($urandom(32'd20240611));
    for (int c = 0; c < 2; c++) begin
      m_dis[c] = 0; m_pend[c] = '0; e_vld[c] = 0; e_addr[c] = 0; e_tag[c] = "R4";
    end
    core_en = 2'b11; timer_irq = 2'b11; exc_req = 2'b11;
    repeat (3) begin
      @(negedge clk);
      chk("R1", int'(entry_vld), 0);
      chk("R1", int'(intr_dis), 0);
    end
    core_en = '0; timer_irq = '0; exc_req = '0;
    @(negedge clk);
    rst_n = 1'b1;

    // R8: secondary held off while every request is raised
    cyc(2'b01, 2'b10, 0, 0, 2'b10, 2'b10, 0, 19, 0);
    cyc(2'b01, 2'b10, 0, 0, 2'b00, 2'b10, 0, 19, 0);
    // R9: number 19 on both cores at once
    cyc(2'b11, 0, 0, 0, 0, 2'b11, 19, 19, 0);
    // R5: exception beats software request and pending hardware
    cyc(2'b11, 2'b11, 1, 1, 2'b01, 2'b11, 3, 5, 2'b11);
    // R7: pending interrupts held while disabled, taken after exit
    cyc(2'b11, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(2'b11, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(2'b11, 0, 0, 0, 0, 0, 0, 0, 2'b11);
    repeat (4) cyc(2'b11, 0, 0, 0, 0, 0, 0, 0, 0);
    // R2: disk and terminal then exit, core 0 only
    cyc(2'b11, 0, 1, 1, 0, 0, 0, 0, 2'b11);
    repeat (4) cyc(2'b11, 0, 0, 0, 0, 0, 0, 0, 2'b11);

    en = 2'b11;
    for (int i = 0; i < 4000; i++) begin
      if (pr(50)) en[1] = ~en[1];
      en[0] = !pr(40);
      cyc(en, {pr(10), pr(10)}, pr(8), pr(8), {pr(16), pr(16)},
          {pr(8), pr(8)}, rnum(), rnum(), {pr(5), pr(5)});
    end
    cyc(2'b11, 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule